// File: doc/BRIEF.md
# Eight-Way Addressable Latch and Active-High Demultiplexer

The block holds a word of single-bit flags, written one bit at a time: a select index picks the bit and a data input gives its new level. Two active-low controls choose between four operating modes. These are writing the addressed bit, holding every bit, steering the data input onto the addressed output while all other outputs go low, and clearing the whole word. One instance can therefore serve as a serial-to-parallel holding register or as a 1-of-N decoder with active-high outputs.

The block is a clocked design. The storage word updates on each rising edge of `clk`, according to the mode present at that edge. Clear mode is the exception: it empties the word at once, without waiting for a clock edge. The output width `N` is a parameter and must be a multiple of eight. The upper select bits choose one eight-bit bank, and the lowest three select bits choose the bit within that bank.

Top module: `addr_latch_bank`

## Requirements
- R1: The select input is an unsigned binary index, with its most significant bit first. Select value i addresses output bit `q[i]`, so 0 addresses `q[0]` and N-1 addresses `q[N-1]`.
- R2: With `clear_n`=1 and `enable_n`=0 (write mode), `q[sel]` takes the value of `din` at the next rising clock edge.
- R3: In write mode, every bit other than `q[sel]` keeps its previous value.
- R4: With `clear_n`=1 and `enable_n`=1 (hold mode), all bits keep their values whatever `sel` and `din` do, for any number of cycles.
- R5: With `clear_n`=0 and `enable_n`=0 (decode mode), at the next rising edge `q[sel]` equals `din` and every other output bit is 0.
- R6: With `clear_n`=0 and `enable_n`=1 (clear mode), all outputs go to 0 without waiting for a clock edge. They stay 0 whatever `sel` and `din` do.
- R7: When decode mode is followed by hold mode, the outputs keep the last decoded pattern. The addressed bit keeps its data value and all other bits stay 0.
- R8: With N above 8, select bits [SEL_W-1:3] pick the bank. A write changes only the selected bank, and the other banks hold. In decode mode every bit outside the addressed one, in every bank, is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock that updates the storage word |
| clear_n | input | 1 | Active-low mode control; with `enable_n` high it clears the word at once |
| enable_n | input | 1 | Active-low mode control; when low, the addressed bit is written or decoded |
| sel | input | $clog2(N) | Binary index of the addressed bit |
| din | input | 1 | Data level applied to the addressed bit |
| q | output | N | Parallel output word |

## Verification
The clock edge and the clear can act in the same cycle. The bench raises clear mode one nanosecond after a rising edge, while a written pattern is on the outputs. It then expects zeros before the next edge, and it keeps expecting zeros across that edge while `sel` and `din` keep changing. A write or a decode at one edge, followed by hold mode with the select moving at the next edge, is the second collision. It is judged by whether the word stays exactly as the previous edge left it.

// File: rtl/al_pkg.sv
package al_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_CLEAR  = 2'd3
  } al_mode_e;

  localparam int unsigned LANES   = 8;
  localparam int unsigned LANE_AW = 3;

  // Map the two active-low controls onto a mode.
  function automatic al_mode_e mode_of(input logic clr_n, input logic en_n);
    if (clr_n) return en_n ? MODE_HOLD : MODE_WRITE;
    else       return en_n ? MODE_CLEAR : MODE_DECODE;
  endfunction

  // One-hot mask of a lane inside an eight-bit bank.
  function automatic logic [LANES-1:0] lane_mask(input logic [LANE_AW-1:0] idx);
    logic [LANES-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
  import al_pkg::*;
(
  input  logic     clear_n,
  input  logic     enable_n,
  output al_mode_e mode,
  output logic     async_clr
);

  always_comb begin
    mode      = mode_of(clear_n, enable_n);
    async_clr = (mode == MODE_CLEAR);
  end

endmodule

// File: rtl/al_bank.sv
module al_bank
  import al_pkg::*;
(
  input  logic               clk,
  input  logic               async_clr,
  input  al_mode_e           mode,
  input  logic               bank_hit,
  input  logic [LANE_AW-1:0] lane,
  input  logic               din,
  output logic [LANES-1:0]   q
);

  logic [LANES-1:0] mask;
  logic [LANES-1:0] q_nxt;
  logic             wr_evt;
  logic             dec_evt;

  assign mask    = lane_mask(lane);
  assign wr_evt  = (mode == MODE_WRITE) && bank_hit;
  assign dec_evt = (mode == MODE_DECODE);

  always_comb begin
    q_nxt = q;
    unique case (mode)
      MODE_WRITE:  if (bank_hit) q_nxt = (q & ~mask) | (mask & {LANES{din}});
      MODE_HOLD:   q_nxt = q;
      MODE_DECODE: q_nxt = bank_hit ? (mask & {LANES{din}}) : '0;
      MODE_CLEAR:  q_nxt = '0;
      default:     q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or posedge async_clr) begin
    if (async_clr) q <= '0;
    else           q <= q_nxt;
  end

  AST_WRITE_LANE: assert property (@(posedge clk) disable iff (async_clr)
    wr_evt |=> q[$past(lane)] == $past(din)); // R2
  AST_WRITE_KEEP: assert property (@(posedge clk) disable iff (async_clr)
    wr_evt |=> ((q ^ $past(q)) & ~$past(mask)) == '0); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (async_clr)
    (mode == MODE_HOLD) |=> $stable(q)); // R4
  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (async_clr)
    dec_evt |=> $countones(q) <= 1); // R5
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (async_clr)
    ((mode == MODE_WRITE) && !bank_hit) |=> $stable(q)); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk)
    async_clr |-> q == '0); // R6

endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import al_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic                 clk,
  input  logic                 clear_n,
  input  logic                 enable_n,
  input  logic [$clog2(N)-1:0] sel,
  input  logic                 din,
  output logic [N-1:0]         q
);

  localparam int unsigned SEL_W = $clog2(N);
  localparam int unsigned BANKS = N / LANES;

  initial begin
    if ((N % LANES) != 0 || N < LANES)
      $error("addr_latch_bank: N must be a non-zero multiple of 8");
  end

  al_mode_e           mode;
  logic               async_clr;
  logic [BANKS-1:0]   hit;
  logic [LANE_AW-1:0] lane;

  assign lane = sel[LANE_AW-1:0];

  al_mode_dec u_mode (
    .clear_n  (clear_n),
    .enable_n (enable_n),
    .mode     (mode),
    .async_clr(async_clr)
  );

  generate
    if (BANKS == 1) begin : g_single
      assign hit = 1'b1;
    end else begin : g_multi
      for (genvar b = 0; b < BANKS; b++) begin : g_hit
        assign hit[b] = (32'(sel[SEL_W-1:LANE_AW]) == b);
      end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      al_bank u_bank (
        .clk      (clk),
        .async_clr(async_clr),
        .mode     (mode),
        .bank_hit (hit[b]),
        .lane     (lane),
        .din      (din),
        .q        (q[b*LANES +: LANES])
      );
    end
  endgenerate

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (async_clr)
    $onehot0(hit) && hit != '0); // R8
  AST_DECODE_HOLD: assert property (@(posedge clk) disable iff (async_clr)
    ($past(mode) == MODE_DECODE && mode == MODE_HOLD) |=> $stable(q)); // R7

endmodule

// File: tb/tb_addr_latch_bank.sv
`timescale 1ns/1ps
module tb_addr_latch_bank;

  logic        clk = 1'b0;
  logic        clear_n, enable_n, din;
  logic [3:0]  sel;
  logic [7:0]  q8;
  logic [15:0] q16;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_latch_bank #(.N(8)) dut (
    .clk(clk), .clear_n(clear_n), .enable_n(enable_n),
    .sel(sel[2:0]), .din(din), .q(q8)
  );

  addr_latch_bank #(.N(16)) dut16 (
    .clk(clk), .clear_n(clear_n), .enable_n(enable_n),
    .sel(sel), .din(din), .q(q16)
  );

  // Vector: {clear_n, enable_n, sel[2:0], din, expected q[7:0]}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0,1'b1,3'd0,1'b0,8'h00},
    {1'b1,1'b0,3'd0,1'b1,8'h01},
    {1'b1,1'b0,3'd7,1'b1,8'h81},
    {1'b1,1'b0,3'd3,1'b1,8'h89},
    {1'b1,1'b1,3'd5,1'b1,8'h89},
    {1'b1,1'b0,3'd0,1'b0,8'h88},
    {1'b1,1'b0,3'd2,1'b1,8'h8C},
    {1'b1,1'b1,3'd1,1'b1,8'h8C},
    {1'b0,1'b0,3'd4,1'b1,8'h10},
    {1'b0,1'b0,3'd6,1'b0,8'h00},
    {1'b0,1'b0,3'd1,1'b1,8'h02},
    {1'b1,1'b1,3'd7,1'b0,8'h02},
    {1'b1,1'b0,3'd5,1'b1,8'h22},
    {1'b0,1'b1,3'd3,1'b1,8'h00}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic e, input logic [3:0] s, input logic d);
    @(negedge clk);
    clear_n = c; enable_n = e; sel = s; din = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    clear_n = 1'b0; enable_n = 1'b1; sel = '0; din = 1'b0;
    #1;
    check("R6 reset state", {8'h00, q8}, 16'h0000);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      string tag;
      v = VEC[i];
      drive(v[13], v[12], {1'b0, v[11:9]}, v[8]);
      case ({v[13], v[12]})
        2'b10:   tag = "R2 table write";
        2'b11:   tag = "R4 table hold";
        2'b00:   tag = "R5 table decode";
        default: tag = "R6 table clear";
      endcase
      check(tag, {8'h00, q8}, {8'h00, v[7:0]});
    end

    // R1: each index lands on its own bit
    for (int i = 0; i < 8; i++) begin
      drive(1'b0, 1'b1, 4'd0, 1'b0);
      drive(1'b1, 1'b0, 4'(i), 1'b1);
      check("R1 index map", {8'h00, q8}, 16'(8'h01 << i));
    end

    // R3: clearing one bit of a full word leaves the rest
    for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 4'(i), 1'b1);
    check("R2 fill", {8'h00, q8}, 16'h00FF);
    drive(1'b1, 1'b0, 4'd2, 1'b0);
    check("R3 others kept", {8'h00, q8}, 16'h00FB);

    // R5 and R7: decode each address, then hold with churning select
    for (int i = 0; i < 8; i++) begin
      drive(1'b0, 1'b0, 4'(i), 1'b1);
      check("R5 decode", {8'h00, q8}, 16'(8'h01 << i));
      drive(1'b1, 1'b1, 4'((i + 3) % 8), 1'b0);
      check("R7 after decode", {8'h00, q8}, 16'(8'h01 << i));
    end

    // R4: hold with moving select and data
    drive(1'b0, 1'b1, 4'd0, 1'b0);
    drive(1'b1, 1'b0, 4'd0, 1'b1);
    drive(1'b1, 1'b0, 4'd2, 1'b1);
    drive(1'b1, 1'b0, 4'd5, 1'b1);
    drive(1'b1, 1'b0, 4'd7, 1'b1);
    check("R2 pattern", {8'h00, q8}, 16'h00A5);
    for (int i = 0; i < 6; i++) begin
      drive(1'b1, 1'b1, 4'(i + 1), i[0]);
      check("R4 hold churn", {8'h00, q8}, 16'h00A5);
    end

    // R6: clear raised mid-cycle takes effect before the next edge
    @(posedge clk);
    #1;
    clear_n = 1'b0; enable_n = 1'b1;
    #1;
    check("R6 mid-cycle clear", {8'h00, q8}, 16'h0000);
    @(negedge clk);
    sel = 4'd6; din = 1'b1;
    @(posedge clk);
    #1;
    check("R6 clear ignores inputs", {8'h00, q8}, 16'h0000);

    // R8: expansion across two banks
    drive(1'b0, 1'b1, 4'd0, 1'b0);
    drive(1'b1, 1'b0, 4'd3, 1'b1);
    drive(1'b1, 1'b0, 4'd10, 1'b1);
    check("R8 two banks", q16, 16'h0408);
    drive(1'b1, 1'b0, 4'd11, 1'b1);
    check("R8 other bank held", q16, 16'h0C08);
    drive(1'b0, 1'b0, 4'd14, 1'b1);
    check("R8 decode across banks", q16, 16'h4000);
    drive(1'b1, 1'b1, 4'd1, 1'b1);
    check("R7 wide hold after decode", q16, 16'h4000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule